// File: doc/BRIEF.md
# Mixed-Precision 4x4 Tile Multiply-Accumulate

This unit evaluates D = A × B + C on square tiles whose side is set by a parameter (4 by default). The two multiplicand tiles carry half-precision floating-point elements. The addend tile and the result tile carry single-precision elements. Each operation performs DIM³ element products and the same number of additions. For the default size that is 64 of each.

A client places the three operand tiles on packed input buses and raises `start_i` for one cycle while the unit is idle. The unit captures all operands at that edge. It then steps through the tile with one shared multiplier and one shared single-precision adder, one product per cycle. When the last element has been written, `done_o` pulses for one cycle and the full result is present on `d_o`.

Each half-precision value is first widened to single-precision range. The product of two widened values fits in 22 significant bits, so the multiply is exact and all rounding happens in the adder.

Top module: `mpmac_tile`

## Requirements
- R1: Every result element is D[i][j] = C[i][j] + A[i][0]·B[0][j] + A[i][1]·B[1][j] + A[i][2]·B[2][j] + A[i][3]·B[3][j], evaluated left to right: the running value starts at C[i][j] and each product is added in increasing k.
- R2: The buses are packed row-major with element [0][0] in the least significant bits. Element (r,c) of A or B sits at bits (r·4+c)·16 upward. Element (r,c) of C or D sits at bits (r·4+c)·32 upward.
- R3: The product of two half-precision inputs is formed without rounding. A product whose exact value fits in single precision reaches the adder unchanged.
- R4: Every addition rounds to nearest, with ties to the even significand.
- R5: Subnormal inputs are treated as zero with their sign kept. This applies to half inputs (exponent field 0) and single inputs (exponent field 0). Results that would be subnormal after rounding are replaced by a zero of the result's sign.
- R6: A NaN on any operand of a product or a sum, infinity times zero, and the sum of opposite infinities all give the single quiet NaN 32'h7FC00000.
- R7: An infinite operand with no NaN case propagates as an infinity of the correct sign. A rounded sum beyond the single-precision range gives a signed infinity.
- R8: A start request seen while idle captures all operands. `done_o` is high for exactly one cycle, 64 clock cycles after the capturing edge.
- R9: While an operation is in progress, `start_i` and changes on the operand buses have no effect. The result belongs to the captured operands, and no second done pulse follows.
- R10: Asserting `rst_n` low aborts any operation and clears `done_o` at once. After release the unit stays idle until a new start.
- R11: A sum that cancels exactly gives +0. The sum of two negative zeros gives −0.
- R12: `d_o` keeps the completed result unchanged after the done pulse until another operation is started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Request to begin an operation; honoured only while idle |
| a_i | input | 256 | Tile A, 16 half-precision elements, row-major |
| b_i | input | 256 | Tile B, 16 half-precision elements, row-major |
| c_i | input | 512 | Tile C, 16 single-precision elements, row-major |
| done_o | output | 1 | One-cycle strobe marking `d_o` complete |
| d_o | output | 512 | Tile D, 16 single-precision elements, row-major |

## Verification
The bench aims at the rounding tie between two representable values. A design that truncates, or that rounds ties away from zero, returns the wrong last bit on the odd-significand elements. Subnormal half and single operands are chosen so that an unflushed design gives tiny nonzero results instead of signed zeros. The same case separates +0 from −0, which catches a design that takes the sign of a cancelled sum from the wrong operand. NaN, infinity-times-zero and opposing-infinity cases catch a design that passes NaN payloads through or lets an infinity win over the invalid case. A start pulse with new operands in the middle of a run exposes a unit that restarts or blends the two tiles. An early reset exposes a done strobe that survives the abort.

// File: rtl/mpmac_pkg.sv
package mpmac_pkg;
  localparam int HALF_W = 16;
  localparam int SNGL_W = 32;
  localparam logic [SNGL_W-1:0] QNAN = 32'h7FC00000;

  // half value widened to single-precision exponent range, 10 fraction bits
  typedef struct packed {
    logic       sgn;
    logic [7:0] exp;
    logic [9:0] man;
  } wide_t;

  function automatic logic f32_is_nan(input logic [SNGL_W-1:0] v);
    return (&v[30:23]) && (|v[22:0]);
  endfunction
endpackage

// File: rtl/mpmac_widen.sv
module mpmac_widen
  import mpmac_pkg::*;
(
  input  logic [HALF_W-1:0] h_i,
  output wide_t             w_o
);
  localparam logic [7:0] REBIAS = 8'd112;  // 127 - 15

  always_comb begin
    w_o.sgn = h_i[15];
    w_o.man = h_i[9:0];
    if (h_i[14:10] == 5'd0) begin
      w_o.exp = 8'd0;             // zero and subnormal flush to signed zero
      w_o.man = 10'd0;
    end else if (&h_i[14:10]) begin
      w_o.exp = 8'hFF;            // infinity / NaN keep their fraction
    end else begin
      w_o.exp = {3'b000, h_i[14:10]} + REBIAS;
    end
  end
endmodule

// File: rtl/mpmac_mul.sv
module mpmac_mul
  import mpmac_pkg::*;
(
  input  wide_t             x_i,
  input  wide_t             y_i,
  output logic [SNGL_W-1:0] p_o
);
  logic        xz, yz, xs, ys, xn, yn, sgn;
  logic [21:0] sig;
  logic [8:0]  ex;
  logic [22:0] frac;

  always_comb begin
    xz   = (x_i.exp == 8'd0);
    yz   = (y_i.exp == 8'd0);
    xs   = &x_i.exp;
    ys   = &y_i.exp;
    xn   = xs && (|x_i.man);
    yn   = ys && (|y_i.man);
    sgn  = x_i.sgn ^ y_i.sgn;
    sig  = {11'd0, 1'b1, x_i.man} * {11'd0, 1'b1, y_i.man};
    ex   = {1'b0, x_i.exp} + {1'b0, y_i.exp} - 9'd127 + {8'd0, sig[21]};
    frac = sig[21] ? {sig[20:0], 2'b00} : {sig[19:0], 3'b000};
    if (xn || yn)               p_o = QNAN;
    else if (xs || ys)          p_o = (xz || yz) ? QNAN : {sgn, 8'hFF, 23'd0};
    else if (xz || yz)          p_o = {sgn, 31'd0};
    else                        p_o = {sgn, ex[7:0], frac};
  end
endmodule

// File: rtl/mpmac_add.sv
module mpmac_add
  import mpmac_pkg::*;
(
  input  logic [SNGL_W-1:0] x_i,
  input  logic [SNGL_W-1:0] y_i,
  output logic [SNGL_W-1:0] s_o
);
  logic               xz, yz, xn, yn, xi, yi, x_big, sub, rup;
  logic [SNGL_W-1:0]  big, sml;
  logic [7:0]         dexp;
  logic [26:0]        bm, smx, sms, nrm;
  logic [53:0]        shw;
  logic [27:0]        rsum;
  logic [4:0]         lz;
  logic signed [9:0]  ex;
  logic [24:0]        rm;
  logic [22:0]        frac;

  always_comb begin
    xz    = (x_i[30:23] == 8'd0);
    yz    = (y_i[30:23] == 8'd0);
    xn    = (&x_i[30:23]) && (|x_i[22:0]);
    yn    = (&y_i[30:23]) && (|y_i[22:0]);
    xi    = (&x_i[30:23]) && !(|x_i[22:0]);
    yi    = (&y_i[30:23]) && !(|y_i[22:0]);
    x_big = (x_i[30:0] >= y_i[30:0]);
    big   = x_big ? x_i : y_i;
    sml   = x_big ? y_i : x_i;
    sub   = big[31] ^ sml[31];
    dexp  = big[30:23] - sml[30:23];
    // alignment: 24-bit significand plus guard, round and sticky positions
    bm    = {1'b1, big[22:0], 3'b000};
    smx   = {1'b1, sml[22:0], 3'b000};
    shw   = {smx, 27'd0} >> dexp;
    sms   = (dexp > 8'd26) ? 27'd1 : {shw[53:28], shw[27] | (|shw[26:0])};
    rsum  = sub ? ({1'b0, bm} - {1'b0, sms}) : ({1'b0, bm} + {1'b0, sms});
    lz    = 5'd0;
    for (int p = 0; p < 27; p++) begin
      if (rsum[p]) lz = 5'(26 - p);
    end
    if (rsum[27]) begin
      nrm = {rsum[27:2], rsum[1] | rsum[0]};
      ex  = $signed({2'b00, big[30:23]}) + 10'sd1;
    end else begin
      nrm = rsum[26:0] << lz;
      ex  = $signed({2'b00, big[30:23]}) - $signed({5'd0, lz});
    end
    rup  = nrm[2] & (nrm[1] | nrm[0] | nrm[3]);
    rm   = {1'b0, nrm[26:3]} + {24'd0, rup};
    frac = rm[24] ? rm[23:1] : rm[22:0];
    if (rm[24]) ex = ex + 10'sd1;

    if (xn || yn || (xi && yi && (x_i[31] != y_i[31]))) s_o = QNAN;
    else if (xi)                 s_o = x_i;
    else if (yi)                 s_o = y_i;
    else if (xz && yz)           s_o = {x_i[31] & y_i[31], 31'd0};
    else if (xz)                 s_o = y_i;
    else if (yz)                 s_o = x_i;
    else if (rsum == 28'd0)      s_o = 32'd0;
    else if (ex >= 10'sd255)     s_o = {big[31], 8'hFF, 23'd0};
    else if (ex <= 10'sd0)       s_o = {big[31], 31'd0};
    else                         s_o = {big[31], ex[7:0], frac};
  end
endmodule

// File: rtl/mpmac_tile.sv
module mpmac_tile
  import mpmac_pkg::*;
#(
  parameter int DIM = 4   // tile side, power of two, at least 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [DIM*DIM*HALF_W-1:0]    a_i,
  input  logic [DIM*DIM*HALF_W-1:0]    b_i,
  input  logic [DIM*DIM*SNGL_W-1:0]    c_i,
  output logic                         done_o,
  output logic [DIM*DIM*SNGL_W-1:0]    d_o
);
  localparam int NEL = DIM * DIM;
  localparam int KW  = $clog2(DIM);
  localparam int CW  = 3 * KW;
  localparam logic [CW-1:0] LAST = CW'(DIM * DIM * DIM - 1);

  logic                     run_q, run_d, done_q, done_d;
  logic [CW-1:0]            cnt_q, cnt_d;
  logic [NEL*HALF_W-1:0]    a_q, b_q;
  logic [NEL*SNGL_W-1:0]    c_q, d_q, d_d;
  logic [SNGL_W-1:0]        acc_q, acc_src, prod, sum;
  logic [KW-1:0]            ri, ci, ki;
  logic [HALF_W-1:0]        a_sel, b_sel;
  wide_t                    a_w, b_w;
  logic                     cap_en, d_en;

  // cnt = {row, column, k}: k runs fastest so one element finishes per DIM steps
  assign ri = cnt_q[3*KW-1:2*KW];
  assign ci = cnt_q[2*KW-1:KW];
  assign ki = cnt_q[KW-1:0];

  always_comb begin
    a_sel   = a_q[(int'(ri) * DIM + int'(ki)) * HALF_W +: HALF_W];
    b_sel   = b_q[(int'(ki) * DIM + int'(ci)) * HALF_W +: HALF_W];
    acc_src = (ki == KW'(0)) ? c_q[(int'(ri) * DIM + int'(ci)) * SNGL_W +: SNGL_W]
                             : acc_q;
  end

  mpmac_widen u_wa (.h_i(a_sel), .w_o(a_w));
  mpmac_widen u_wb (.h_i(b_sel), .w_o(b_w));
  mpmac_mul   u_mul (.x_i(a_w), .y_i(b_w), .p_o(prod));
  mpmac_add   u_add (.x_i(acc_src), .y_i(prod), .s_o(sum));

  // next-state logic
  always_comb begin
    cap_en = !run_q && start_i;
    d_en   = run_q && (ki == KW'(DIM - 1));
    run_d  = run_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    d_d    = d_q;
    d_d[(int'(ri) * DIM + int'(ci)) * SNGL_W +: SNGL_W] = sum;
    if (cap_en) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        run_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  // datapath registers, clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (cap_en) begin
      a_q <= a_i;
      b_q <= b_i;
      c_q <= c_i;
    end
    if (run_q) acc_q <= sum;
    if (d_en)  d_q   <= d_d;
  end

  assign done_o = done_q;
  assign d_o    = d_q;

  // R8: the done strobe lasts a single cycle and closes the last step
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(cnt_q) == LAST);
  // R9: a running operation advances one step per cycle whatever start does
  a_r9_busy_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != LAST) |=> (run_q && cnt_q == $past(cnt_q) + CW'(1)));
  // R6: a NaN reaching the adder leaves as the canonical quiet NaN
  a_r6_nan_canonical: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && (f32_is_nan(acc_src) || f32_is_nan(prod))) |-> sum == QNAN);
  // R3: a finite nonzero product carries at most 22 significant bits
  a_r3_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && prod[30:23] != 8'd0 && !(&prod[30:23])) |-> prod[1:0] == 2'b00);
  // R5: the adder never emits a subnormal pattern
  a_r5_no_subnormal: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (sum[30:23] != 8'd0 || sum[22:0] == 23'd0));
endmodule

// File: tb/mpmac_tile_bench.sv
`timescale 1ns/1ps
module mpmac_tile_bench;
  logic         clk, rst_n, start_i, done_o;
  logic [255:0] a_i, b_i;
  logic [511:0] c_i, d_o;
  int           total, bad;
  logic [31:0]  lfsr;

  mpmac_tile u_mpmac_tile (.clk(clk), .rst_n(rst_n), .start_i(start_i),
    .a_i(a_i), .b_i(b_i), .c_i(c_i), .done_o(done_o), .d_o(d_o));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- independent reference model ----------------
  function automatic real h2r(input logic [15:0] h);
    if (h[14:10] == 5'd0) return $bitstoreal({h[15], 63'd0});
    if (&h[14:10]) return (|h[9:0]) ? $bitstoreal(64'h7FF8000000000000)
                                    : $bitstoreal({h[15], 11'h7FF, 52'd0});
    return $bitstoreal({h[15], 11'({6'd0, h[14:10]}) + 11'd1008, h[9:0], 42'd0});
  endfunction

  function automatic real f2r(input logic [31:0] x);
    if (x[30:23] == 8'd0) return $bitstoreal({x[31], 63'd0});
    if (&x[30:23]) return (|x[22:0]) ? $bitstoreal(64'h7FF8000000000000)
                                     : $bitstoreal({x[31], 11'h7FF, 52'd0});
    return $bitstoreal({x[31], 11'({3'd0, x[30:23]}) + 11'd896, x[22:0], 29'd0});
  endfunction

  function automatic logic [31:0] r2f(input real r);
    logic [63:0] b;
    logic [52:0] mant;
    logic [24:0] m;
    int          e;
    b = $realtobits(r);
    if (&b[62:52]) return (|b[51:0]) ? 32'h7FC00000 : {b[63], 8'hFF, 23'd0};
    if (b[62:52] == 11'd0) return {b[63], 31'd0};
    e    = int'(b[62:52]) - 896;
    mant = {1'b1, b[51:0]};
    m    = {1'b0, mant[52:29]};
    if (mant[28] && ((|mant[27:0]) || mant[29])) m = m + 25'd1;
    if (m[24]) begin e = e + 1; m = m >> 1; end
    if (e >= 255) return {b[63], 8'hFF, 23'd0};
    if (e <= 0) return {b[63], 31'd0};
    return {b[63], 8'(e), m[22:0]};
  endfunction

  function automatic logic [511:0] model(input logic [255:0] a, b, input logic [511:0] c);
    logic [511:0] d;
    logic [31:0]  acc, p;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        acc = c[(i*4+j)*32 +: 32];
        for (int k = 0; k < 4; k++) begin
          p   = r2f(h2r(a[(i*4+k)*16 +: 16]) * h2r(b[(k*4+j)*16 +: 16]));
          acc = r2f(f2r(acc) + f2r(p));
        end
        d[(i*4+j)*32 +: 32] = acc;
      end
    end
    return d;
  endfunction

  function automatic logic [15:0] int2h(input int n);
    int e;
    e = 0;
    for (int t = 1; t < 12; t++) if (n >= (1 << t)) e = t;
    return {1'b0, 5'(e + 15), 10'((n << (10 - e)) & 1023)};
  endfunction

  function automatic logic [31:0] rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr;
  endfunction

  // ---------------- check helpers ----------------
  task automatic chk32(input string req, input logic [31:0] act, exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_tile(input string req, input logic [511:0] act, exp);
    for (int e = 0; e < 16; e++) begin
      total++;
      if (act[e*32 +: 32] !== exp[e*32 +: 32]) begin
        bad++;
        $display("FAIL %s element %0d: actual=%h expected=%h",
                 req, e, act[e*32 +: 32], exp[e*32 +: 32]);
      end
    end
  endtask

  task automatic run_op(input logic [255:0] a, b, input logic [511:0] c,
                        output logic [511:0] d, output int lat);
    @(negedge clk);
    a_i = a; b_i = b; c_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    d = d_o;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk32("R10 reset done low", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_identity();   // R1 R2 R8
    logic [255:0] a, b;
    logic [511:0] c, d;
    int lat;
    a = '0; c = '0;
    for (int i = 0; i < 4; i++) a[(i*4+i)*16 +: 16] = 16'h3C00;
    for (int e = 0; e < 16; e++) b[e*16 +: 16] = int2h(e + 1);
    run_op(a, b, c, d, lat);
    chk32("R8 latency", 32'(lat), 32'd64);
    chk32("R2 element (1,2)", d[6*32 +: 32], 32'h40E00000);
    chk_tile("R1 identity tile", d, model(a, b, c));
  endtask

  task automatic t_random(input int rounds, input bit raw);   // R1 R3 R4
    logic [255:0] a, b;
    logic [511:0] c, d;
    logic [31:0]  r;
    int lat;
    for (int n = 0; n < rounds; n++) begin
      for (int e = 0; e < 16; e++) begin
        r = rnd();
        a[e*16 +: 16] = raw ? r[15:0] : {r[15], r[14] ? 2'b10 : 2'b01, r[12:0]};
        r = rnd();
        b[e*16 +: 16] = raw ? r[31:16] : {r[31], r[30] ? 2'b10 : 2'b01, r[28:16]};
        r = rnd();
        c[e*32 +: 32] = raw ? r : {r[31], 5'b10000, r[25:0]};
      end
      run_op(a, b, c, d, lat);
      chk_tile(raw ? "R1 raw random" : "R4 random rounding", d, model(a, b, c));
    end
  endtask

  task automatic t_tie();   // R4: 1 + 2^-24 and (1+2^-23) + 2^-24
    logic [255:0] a, b;
    logic [511:0] c, d;
    int lat;
    a = '0; b = '0;
    for (int i = 0; i < 4; i++) a[(i*4)*16 +: 16] = 16'h0C00;
    for (int j = 0; j < 4; j++) b[j*16 +: 16] = 16'h0C00;
    for (int e = 0; e < 16; e++) c[e*32 +: 32] = (e % 2 == 1) ? 32'h3F800001 : 32'h3F800000;
    run_op(a, b, c, d, lat);
    chk32("R4 tie to even, even lsb", d[0 +: 32], 32'h3F800000);
    chk32("R4 tie to even, odd lsb", d[32 +: 32], 32'h3F800002);
    chk_tile("R4 tie tile", d, model(a, b, c));
  endtask

  task automatic t_special();   // R6 R7
    logic [255:0] a, b;
    logic [511:0] c, d;
    int lat;
    for (int e = 0; e < 16; e++) begin
      a[e*16 +: 16] = 16'h3C00;
      b[e*16 +: 16] = 16'h4000;
      c[e*32 +: 32] = 32'h3F800000;
    end
    a[0 +: 16]        = 16'h7E01;       // NaN in row 0
    a[(1*4)*16 +: 16] = 16'h7C00;       // +inf in row 1
    b[3*16 +: 16]     = 16'h0000;       // column 3 of row k=0 is zero
    c[(2*4+0)*32 +: 32] = 32'hFF800000; // -inf addend
    c[(2*4+1)*32 +: 32] = 32'h7FA00000; // signalling NaN addend
    a[(3*4)*16 +: 16]   = 16'h7C00;
    c[(3*4+0)*32 +: 32] = 32'hFF800000; // -inf + +inf
    run_op(a, b, c, d, lat);
    chk32("R6 NaN operand", d[0 +: 32], 32'h7FC00000);
    chk32("R7 inf times finite", d[(1*4+0)*32 +: 32], 32'h7F800000);
    chk32("R6 inf times zero", d[(1*4+3)*32 +: 32], 32'h7FC00000);
    chk32("R7 negative inf addend", d[(2*4+0)*32 +: 32], 32'hFF800000);
    chk32("R6 signalling NaN addend", d[(2*4+1)*32 +: 32], 32'h7FC00000);
    chk32("R6 opposite infinities", d[(3*4+0)*32 +: 32], 32'h7FC00000);
    chk_tile("R6 special tile", d, model(a, b, c));
  endtask

  task automatic t_subnormal(input bit neg);   // R5 R11
    logic [255:0] a, b;
    logic [511:0] c, d, e;
    int lat;
    for (int k = 0; k < 16; k++) begin
      a[k*16 +: 16] = neg ? 16'h8200 : 16'h0200;
      b[k*16 +: 16] = 16'h3C00;
      c[k*32 +: 32] = 32'h80000005;
      e[k*32 +: 32] = neg ? 32'h80000000 : 32'h00000000;
    end
    run_op(a, b, c, d, lat);
    chk_tile(neg ? "R11 negative zero sum" : "R5 subnormal flush", d, e);
  endtask

  task automatic t_cancel();   // R11
    logic [255:0] a, b;
    logic [511:0] c, d;
    int lat;
    a = '0;
    for (int i = 0; i < 4; i++) a[(i*4+i)*16 +: 16] = 16'h3C00;
    for (int k = 0; k < 16; k++) begin
      b[k*16 +: 16] = 16'h3C00;
      c[k*32 +: 32] = 32'hBF800000;
    end
    run_op(a, b, c, d, lat);
    chk_tile("R11 exact cancellation", d, '0);
  endtask

  task automatic t_busy();   // R9 R12
    logic [255:0] a, b;
    logic [511:0] c, d, want;
    int lat, extra;
    for (int e = 0; e < 16; e++) begin
      a[e*16 +: 16] = int2h(e + 2);
      b[e*16 +: 16] = int2h(17 - e);
      c[e*32 +: 32] = 32'h3F000000;
    end
    want = model(a, b, c);
    @(negedge clk);
    a_i = a; b_i = b; c_i = c; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    repeat (10) begin @(negedge clk); lat++; end
    a_i = ~a; b_i = ~b; c_i = '0; start_i = 1'b1;
    @(negedge clk);
    lat++;
    start_i = 1'b0;
    while (!done_o && lat < 200) begin @(negedge clk); lat++; end
    chk32("R9 latency unaffected by start", 32'(lat), 32'd64);
    d = d_o;
    chk_tile("R9 result of captured operands", d, want);
    extra = 0;
    repeat (80) begin @(negedge clk); if (done_o) extra++; end
    chk32("R9 no second done", 32'(extra), 32'd0);
    chk_tile("R12 result held", d_o, want);
  endtask

  task automatic t_reset_mid();   // R10
    logic [511:0] d;
    int lat, seen;
    @(negedge clk);
    a_i = '1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk32("R10 done low in reset", {31'd0, done_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0;
    repeat (80) begin @(negedge clk); if (done_o) seen++; end
    chk32("R10 idle after reset", 32'(seen), 32'd0);
    run_op('0, '0, '0, d, lat);
    chk32("R10 new op after reset", 32'(lat), 32'd64);
  endtask

  initial begin
    total = 0; bad = 0; lfsr = 32'h1234ABCD;
    rst_n = 1'b0; start_i = 1'b0; a_i = '0; b_i = '0; c_i = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_identity();
    t_tie();
    t_random(6, 1'b0);
    t_random(4, 1'b1);
    t_special();
    t_subnormal(1'b0);
    t_subnormal(1'b1);
    t_cancel();
    t_busy();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule